// File: doc/BRIEF.md
# Level Interrupt Gathering Controller

This block collects 64 level-sensitive interrupt lines into one processor interrupt request. Every source owns a latched flag and an enable bit. A flag is set on any clock edge where its line is high. Software clears it by writing ones to a byte-addressed clear array. The masked view (flag AND enable) is read back as two 32-bit words. Software scans the low word (sources 0 to 31) before the extended word (sources 32 to 63), and lowest bit first, so the lowest-numbered pending source is serviced first.

The register bus is synchronous. Each access has a word-aligned address, four byte-lane enables and combinational read data. This lets software do byte-wide read-modify-write on the enable words. A routing byte picks which of the processor's interrupt channels carries the combined request. Writing 1 selects channel 1, the regular (non-fast) request path. A held level re-raises its flag even if a clear arrives in the same cycle, so a source that is still asserted can never be lost.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After synchronous reset, all enable bits are 0, all flags are 0, the routing byte is 0 and every bit of `irq_out` is 0.
- R2: A source that is high at a rising clock edge has its flag set after that edge, and the flag stays set after the source falls, until it is cleared.
- R3: A read of word offset 0x58 returns bit i = flag(i) AND enable(i) for sources 0 to 31. A read of 0x5C returns bit i for source 32+i. A flag whose enable bit is 0 reads as 0 but stays latched, and it shows up once the enable bit is set.
- R4: Enables for sources 0 to 31 are at word offset 0x50 and for sources 32 to 63 at 0x54, with bit i of each word matching the status layout. A write updates only the byte lanes whose lane enable is 1 (lane b holds bits 8b to 8b+7), and the whole word reads back.
- R5: Clear byte n (byte address 0x40+n, which is lane n mod 4 of word 0x40 or 0x44) covers sources 8n to 8n+7. Writing 1 to a bit clears that flag. Zero bits and unselected lanes leave flags unchanged.
- R6: If a source is high in the same cycle that its flag is cleared, the flag stays set.
- R7: The routing byte is at word offset 0x3A4, lane 0, and reads back in bits 7:0. `irq_out[c]` is high exactly when some status bit is 1 and the routing byte equals c. A routing value of `NUM_CH` or more drives no channel.
- R8: Reads from any offset not listed in R3, R4 or R7 (including the clear array and 0x60) return 0. Writes to offsets not listed in R4, R5 or R7 (including 0x48, 0x58 and 0x60) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Level interrupt lines, bit i is source i |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits 1:0 ignored |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_out | output | NUM_CH | Combined request, one bit per processor channel |

## Verification
If a flag is wrong inside the block, it shows up in the status words and on `irq_out` in the first cycle after the offending edge. This is the case for a flag missed when a line was high, a flag dropped without a clear write, or a clear that wins over a held level. A corrupted enable byte is visible at once on a readback of 0x50 or 0x54. It also shows as a masked source that still drives the request, or an enabled one that does not. A wrong routing byte moves or removes the request on `irq_out` in the cycle after the write.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    localparam int WORD_W         = 32;
    localparam int LANES          = WORD_W / 8;
    localparam int ROUTE_W        = 8;

    // Byte offsets of the register regions
    localparam logic [11:0] OFS_CLR_BASE = 12'h040;
    localparam logic [11:0] OFS_EN_BASE  = 12'h050;
    localparam logic [11:0] OFS_ST_BASE  = 12'h058;
    localparam logic [11:0] OFS_ROUTE    = 12'h3A4;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CLR,
        REG_EN,
        REG_ST,
        REG_ROUTE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  word;
    } reg_hit_t;

    // Expand lane enables into a bit mask
    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < LANES; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_gather_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);
    localparam int WA_W = ADDR_W - 2;

    localparam logic [WA_W-1:0] WA_CLR   = WA_W'(OFS_CLR_BASE >> 2);
    localparam logic [WA_W-1:0] WA_EN    = WA_W'(OFS_EN_BASE >> 2);
    localparam logic [WA_W-1:0] WA_ST    = WA_W'(OFS_ST_BASE >> 2);
    localparam logic [WA_W-1:0] WA_ROUTE = WA_W'(OFS_ROUTE >> 2);

    logic [WA_W-1:0] waddr;
    assign waddr = addr[ADDR_W-1:2];

    always_comb begin
        hit.kind = REG_NONE;
        hit.word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (waddr == WA_CLR + WA_W'(w)) begin
                hit.kind = REG_CLR;
                hit.word = 4'(w);
            end
            if (waddr == WA_EN + WA_W'(w)) begin
                hit.kind = REG_EN;
                hit.word = 4'(w);
            end
            if (waddr == WA_ST + WA_W'(w)) begin
                hit.kind = REG_ST;
                hit.word = 4'(w);
            end
        end
        if (waddr == WA_ROUTE) begin
            hit.kind = REG_ROUTE;
            hit.word = '0;
        end
    end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_gather_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_stb,
    input  logic [3:0]                    word_idx,
    input  logic [LANES-1:0]              be,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NUM_WORDS*WORD_W-1:0]   en_vec
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_vec[w*WORD_W + 8*b +: 8] <= '0;
                end else if (wr_stb && word_idx == 4'(w) && be[b]) begin
                    en_vec[w*WORD_W + 8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_gather_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_WORDS*WORD_W-1:0]   src,
    input  logic                          clr_stb,
    input  logic [3:0]                    word_idx,
    input  logic [LANES-1:0]              be,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NUM_WORDS*WORD_W-1:0]   flag_vec
);
    logic [NUM_WORDS*WORD_W-1:0] clr_vec;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
        assign clr_vec[w*WORD_W +: WORD_W] =
            (clr_stb && word_idx == 4'(w)) ? (wdata & lane_mask(be)) : '0;
    end

    // A held level beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_vec <= '0;
        end else begin
            flag_vec <= (flag_vec & ~clr_vec) | src;
        end
    end

endmodule

// File: rtl/irq_route_out.sv
module irq_route_out
    import irq_gather_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [7:0]         wdata_byte,
    input  logic               pending,
    output logic [ROUTE_W-1:0] route_val,
    output logic [NUM_CH-1:0]  irq_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            route_val <= '0;
        end else if (wr_stb) begin
            route_val <= wdata_byte;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign irq_out[c] = pending && (route_val == ROUTE_W'(c));
    end

endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
    import irq_gather_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CH  = 4,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CH-1:0]  irq_out
);
    localparam int NUM_WORDS = NUM_SRC / WORD_W;

    reg_hit_t                    hit;
    logic                        wr_stb;
    logic                        clr_wr;
    logic                        en_wr;
    logic                        route_wr;
    logic [NUM_SRC-1:0]          flag_vec;
    logic [NUM_SRC-1:0]          en_vec;
    logic [NUM_SRC-1:0]          status_vec;
    logic [ROUTE_W-1:0]          route_val;

    irq_bus_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign wr_stb   = bus_sel && bus_wr;
    assign clr_wr   = wr_stb && (hit.kind == REG_CLR);
    assign en_wr    = wr_stb && (hit.kind == REG_EN);
    assign route_wr = wr_stb && (hit.kind == REG_ROUTE) && bus_be[0];

    irq_enable_bank #(.NUM_WORDS(NUM_WORDS)) u_en (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (en_wr),
        .word_idx (hit.word),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .en_vec   (en_vec)
    );

    irq_flag_bank #(.NUM_WORDS(NUM_WORDS)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .src      (irq_src),
        .clr_stb  (clr_wr),
        .word_idx (hit.word),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .flag_vec (flag_vec)
    );

    assign status_vec = flag_vec & en_vec;

    irq_route_out #(.NUM_CH(NUM_CH)) u_route (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (route_wr),
        .wdata_byte (bus_wdata[7:0]),
        .pending    (|status_vec),
        .route_val  (route_val),
        .irq_out    (irq_out)
    );

    // Combinational read mux; unmapped and clear offsets read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (hit.kind)
                REG_EN:    bus_rdata = en_vec[int'(hit.word)*WORD_W +: WORD_W];
                REG_ST:    bus_rdata = status_vec[int'(hit.word)*WORD_W +: WORD_W];
                REG_ROUTE: bus_rdata = {{(WORD_W-ROUTE_W){1'b0}}, route_val};
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CH  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_src,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] enables,
    input logic [7:0]         route,
    input logic               clr_wr,
    input logic [NUM_CH-1:0]  irq_out
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0 && enables == '0 && route == 8'd0 && irq_out == '0));

    assert_src_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_src != '0) |=> ((flags & $past(irq_src)) == $past(irq_src)));

    assert_flag_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (($past(flags) & ~flags) != '0) |-> $past(clr_wr));

    assert_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr) |=> $stable(enables));

    assert_single_channel_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_out));

    assert_quiet_when_masked_R3: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables) == '0) |-> (irq_out == '0));

endmodule

bind irq_gather_ctrl irq_gather_chk #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_src (irq_src),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .flags   (flag_vec),
    .enables (en_vec),
    .route   (route_val),
    .clr_wr  (clr_wr),
    .irq_out (irq_out)
);

// File: tb/test_irq_gather_ctrl.sv
module test_irq_gather_ctrl;

    localparam int NUM_SRC = 64;
    localparam int NUM_CH  = 4;
    localparam int ADDR_W  = 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] irq_src = '0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [3:0]         bus_be = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_CH-1:0]  irq_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    irq_gather_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_irq_gather_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // {source pattern, enable pattern}
    localparam logic [127:0] VECS [6] = '{
        {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001},
        {64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'hFFFF_0000_0000_FFFF, 64'h0F0F_0F0F_F0F0_F0F0},
        {64'h0000_0000_0000_00A5, 64'h0000_0000_0000_0000},
        {64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001}
    };

    logic [63:0] vsrc, ven, vexp;
    logic [31:0] rd;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_src(input logic [63:0] p);
        @(negedge clk);
        irq_src = p;
        @(negedge clk);
        irq_src = '0;
    endtask

    task automatic clear_all();
        bus_write(12'h040, 4'hF, 32'hFFFF_FFFF);
        bus_write(12'h044, 4'hF, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(12'h050, rd); check("R1 en lo", rd, 0);
        bus_read(12'h054, rd); check("R1 en hi", rd, 0);
        bus_read(12'h058, rd); check("R1 st lo", rd, 0);
        bus_read(12'h05C, rd); check("R1 st hi", rd, 0);
        bus_read(12'h3A4, rd); check("R1 route", rd, 0);
        check("R1 irq_out", irq_out, 0);

        // Table walk: R3 masking, R7 channel 0 request
        for (int i = 0; i < 6; i++) begin
            vsrc = VECS[i][127:64];
            ven  = VECS[i][63:0];
            vexp = vsrc & ven;
            clear_all();
            bus_write(12'h050, 4'hF, ven[31:0]);
            bus_write(12'h054, 4'hF, ven[63:32]);
            pulse_src(vsrc);
            bus_read(12'h058, rd); check("R3 table st lo", rd, vexp[31:0]);
            bus_read(12'h05C, rd); check("R3 table st hi", rd, vexp[63:32]);
            check("R7 table irq_out", irq_out, (vexp != 0) ? 4'b0001 : 4'b0000);
        end

        // R2 latch persists; R3 late enable reveals it
        clear_all();
        bus_write(12'h050, 4'hF, 32'h0);
        bus_write(12'h054, 4'hF, 32'h0);
        pulse_src(64'h0000_0000_0000_0020);
        repeat (4) @(negedge clk);
        bus_read(12'h058, rd); check("R3 masked reads zero", rd, 0);
        check("R3 masked no irq", irq_out, 0);
        bus_write(12'h050, 4'hF, 32'hFFFF_FFFF);
        bus_read(12'h058, rd); check("R2 flag held after source low", rd, 32'h0000_0020);

        // R4 byte-lane enable writes
        bus_write(12'h050, 4'hF, 32'h0);
        bus_write(12'h050, 4'b0100, 32'hAABB_CCDD);
        bus_read(12'h050, rd); check("R4 single lane", rd, 32'h00BB_0000);
        bus_write(12'h054, 4'hF, 32'h1234_5678);
        bus_write(12'h054, 4'b0001, 32'h0000_00FF);
        bus_read(12'h054, rd); check("R4 lane rmw", rd, 32'h1234_56FF);

        // R5 byte clear
        bus_write(12'h050, 4'hF, 32'hFFFF_FFFF);
        bus_write(12'h054, 4'hF, 32'hFFFF_FFFF);
        pulse_src({64{1'b1}});
        bus_write(12'h044, 4'b0010, 32'h0000_8100);
        bus_read(12'h05C, rd); check("R5 clear byte5 bits", rd, 32'hFFFF_7EFF);
        bus_write(12'h040, 4'b0000, 32'hFFFF_FFFF);
        bus_read(12'h058, rd); check("R5 no lane no clear", rd, 32'hFFFF_FFFF);

        // R6 set beats clear
        clear_all();
        pulse_src(64'h10);
        @(negedge clk);
        irq_src = 64'h08;
        bus_write(12'h040, 4'b0001, 32'h0000_0018);
        bus_read(12'h058, rd); check("R6 held level survives clear", rd, 32'h0000_0008);
        irq_src = '0;
        bus_write(12'h040, 4'b0001, 32'h0000_0008);
        bus_read(12'h058, rd); check("R6 clear after release", rd, 0);

        // R8 unmapped accesses
        pulse_src(64'h0000_0000_FFFF_FFFF);
        bus_write(12'h050, 4'hF, 32'h0000_FFFF);
        bus_write(12'h048, 4'hF, 32'hFFFF_FFFF);
        bus_write(12'h058, 4'hF, 32'h0);
        bus_write(12'h060, 4'hF, 32'hFFFF_FFFF);
        bus_write(12'h3A8, 4'hF, 32'hFFFF_FFFF);
        bus_read(12'h058, rd); check("R8 status unchanged", rd, 32'h0000_FFFF);
        bus_read(12'h050, rd); check("R8 enable unchanged", rd, 32'h0000_FFFF);
        bus_read(12'h3A4, rd); check("R8 route unchanged", rd, 0);
        bus_read(12'h060, rd); check("R8 unmapped read", rd, 0);
        bus_read(12'h040, rd); check("R8 clear array reads zero", rd, 0);

        // R7 routing
        bus_write(12'h3A4, 4'b0001, 32'h0000_0001);
        bus_read(12'h3A4, rd); check("R7 route readback", rd, 1);
        check("R7 channel 1", irq_out, 4'b0010);
        bus_write(12'h3A4, 4'b0001, 32'h0000_0003);
        check("R7 channel 3", irq_out, 4'b1000);
        bus_write(12'h3A4, 4'b0001, 32'h0000_0007);
        check("R7 out of range", irq_out, 4'b0000);
        bus_write(12'h3A4, 4'b0000, 32'h0000_0001);
        check("R7 no lane keeps route", irq_out, 4'b0000);
        bus_write(12'h3A4, 4'b0001, 32'h0000_0000);
        check("R7 channel 0", irq_out, 4'b0001);
        clear_all();
        check("R7 nothing pending", irq_out, 4'b0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule